// File: doc/BRIEF.md
# Frequency Counter Gate Sequencer

This block produces the timing signals for a decimal frequency counter. It runs from a fast system clock and drives a gate window. While the gate is high, the external counter chain counts input edges and the display storage keeps showing the previous result. When the window closes, the block sends a short active-low latch strobe, which copies the finished count into the display storage. After one quiet cycle it sends a short active-high clear strobe, which zeroes the counters ready for the next window. Both strobes fall inside the idle part of the period, so they never cut into counting. Because the counters are cleared at least once in every period, they need no separate power-on clear.

A two-bit range input picks a gate time of 0.1 s, 1 s or 10 s, so the count equals f/10, f or 10·f. In the default symmetric mode the idle time equals the gate time. A short-window mode counts for 0.1 s and then holds the display for 0.9 s. The chosen setting is captured only on the edge at which a window opens. A two-bit range code reports the effective gate time of the result that was latched most recently, so decimal-point logic downstream can follow the display.

Top module: `gate_sequencer`

## Requirements
- R1: While `rst` is high the outputs are gate=0, latch_n=1, clear=1 and range_code=01. After release, clear stays high for STROBE_W more cycles, latch_n stays high, and gate rises LO−STROBE_W−1 cycles after release. LO is the idle length set by the inputs held during reset.
- R2: The gate stays high for exactly T·10^k cycles, where T = CLK_HZ/10. The value of k comes from range_sel: 00 gives k=0 (0.1 s), 01 gives k=1 (1 s), 10 gives k=2 (10 s), and 11 is treated as 01.
- R3: With short_mode=0 the gate stays low for exactly as many cycles as the preceding high window lasted.
- R4: With short_mode=1 the gate is high for T cycles and low for 9·T cycles, whatever range_sel says.
- R5: After every counting window, latch_n is low for exactly STROBE_W cycles, starting in the first cycle in which gate is low.
- R6: clear is high for exactly STROBE_W cycles, starting one cycle after latch_n returns high. latch_n low and clear high never occur in the same cycle.
- R7: While gate is high, latch_n is high and clear is low.
- R8: range_sel and short_mode are sampled only on the clock edge at which gate rises. A change at any other time leaves the current high and low durations unchanged.
- R9: range_code holds the effective gate time of the most recently latched window: 00 means 0.1 s (this includes short_mode), 01 means 1 s and 10 means 10 s. It changes only in the first cycle of a latch strobe and holds its value in every other cycle.
- R10: Between one fall of gate and the next rise, clear is asserted at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ hertz |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Gate time select: 00 = 0.1 s, 01 = 1 s, 10 = 10 s, 11 = 1 s |
| short_mode | input | 1 | 1 = count 0.1 s, then hold for 0.9 s |
| gate | output | 1 | High while input edges are to be counted |
| latch_n | output | 1 | Active-low strobe that stores the finished count |
| clear | output | 1 | Active-high strobe that zeroes the counters |
| range_code | output | 2 | Effective gate time of the latched result |

## Verification
Two things can happen in the same cycle: a change on the range inputs, and the edge that opens a window and captures them. The bench aims a change at the last idle cycle before a rise, which must take effect for that window. It then aims a second change at the cycle right after the rise, which must not take effect until the following window. Each measured high and low duration is compared with the value computed from the setting that was present at the opening edge. The bench also checks that the range code moves in the same cycle as the first latch strobe and never between strobes.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [2:0] {
    PH_COUNT = 3'd0,
    PH_LATCH = 3'd1,
    PH_GAP   = 3'd2,
    PH_CLEAR = 3'd3,
    PH_REST  = 3'd4
  } phase_t;

  typedef struct packed {
    logic [1:0] code;
    logic       short_m;
  } gcfg_t;

  // Effective gate-time code: 0 = 0.1 s, 1 = 1 s, 2 = 10 s
  function automatic logic [1:0] eff_code(input logic [1:0] sel, input logic sm);
    if (sm)               return 2'd0;
    else if (sel == 2'd3) return 2'd1;
    else                  return sel;
  endfunction

endpackage

// File: rtl/gseq_cfg.sv
module gseq_cfg
  import gseq_pkg::*;
#(
  parameter int T100  = 5_000_000,
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       range_sel,
  input  logic             short_mode,
  input  logic             take,
  output logic [CNT_W-1:0] live_hi,
  output logic [CNT_W-1:0] cur_lo,
  output logic [1:0]       cur_code
);

  localparam logic [CNT_W-1:0] LEN_S  = CNT_W'(T100);
  localparam logic [CNT_W-1:0] LEN_M  = CNT_W'(10 * T100);
  localparam logic [CNT_W-1:0] LEN_L  = CNT_W'(100 * T100);
  localparam logic [CNT_W-1:0] LEN_H9 = CNT_W'(9 * T100);

  gcfg_t live_cfg;
  gcfg_t cfg_q;

  always_comb begin
    live_cfg.code    = eff_code(range_sel, short_mode);
    live_cfg.short_m = short_mode;
  end

  always_comb begin
    case (live_cfg.code)
      2'd0:    live_hi = LEN_S;
      2'd1:    live_hi = LEN_M;
      default: live_hi = LEN_L;
    endcase
  end

  always_comb begin
    if (cfg_q.short_m) cur_lo = LEN_H9;
    else begin
      case (cfg_q.code)
        2'd0:    cur_lo = LEN_S;
        2'd1:    cur_lo = LEN_M;
        default: cur_lo = LEN_L;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || take) cfg_q <= live_cfg;
  end

  assign cur_code = cfg_q.code;

endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
  import gseq_pkg::*;
#(
  parameter int CNT_W    = 29,
  parameter int STROBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output phase_t           phase_q,
  output phase_t           phase_nxt,
  output logic             take
);

  localparam logic [CNT_W-1:0] STB_LOAD  = CNT_W'(STROBE_W - 1);
  localparam logic [CNT_W-1:0] REST_TRIM = CNT_W'(2 * STROBE_W + 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_end;

  assign at_end = (cnt_q == '0);
  assign take   = (phase_q == PH_REST) && at_end;

  always_comb begin
    phase_nxt = phase_q;
    cnt_nxt   = cnt_q - 1'b1;
    if (at_end) begin
      case (phase_q)
        PH_COUNT: begin phase_nxt = PH_LATCH; cnt_nxt = STB_LOAD;             end
        PH_LATCH: begin phase_nxt = PH_GAP;   cnt_nxt = '0;                   end
        PH_GAP:   begin phase_nxt = PH_CLEAR; cnt_nxt = STB_LOAD;             end
        PH_CLEAR: begin phase_nxt = PH_REST;  cnt_nxt = lo_len - REST_TRIM;   end
        default:  begin phase_nxt = PH_COUNT; cnt_nxt = hi_len - 1'b1;        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CLEAR;
      cnt_q   <= STB_LOAD;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

endmodule

// File: rtl/gseq_out.sv
module gseq_out
  import gseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_t     phase_q,
  input  phase_t     phase_nxt,
  input  logic [1:0] cur_code,
  output logic       gate,
  output logic       latch_n,
  output logic       clear,
  output logic [1:0] range_code
);

  logic latch_start;
  assign latch_start = (phase_nxt == PH_LATCH) && (phase_q != PH_LATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate       <= 1'b0;
      latch_n    <= 1'b1;
      clear      <= 1'b1;
      range_code <= 2'd1;
    end else begin
      gate    <= (phase_nxt == PH_COUNT);
      latch_n <= (phase_nxt != PH_LATCH);
      clear   <= (phase_nxt == PH_CLEAR);
      if (latch_start) range_code <= cur_code;
    end
  end

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gseq_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int STROBE_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] range_sel,
  input  logic       short_mode,
  output logic       gate,
  output logic       latch_n,
  output logic       clear,
  output logic [1:0] range_code
);

  localparam int T100    = CLK_HZ / 10;
  localparam int MAX_LEN = 100 * T100;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] hi_len;
  logic [CNT_W-1:0] lo_len;
  logic [1:0]       cur_code;
  logic             take;
  phase_t           phase_q;
  phase_t           phase_nxt;

  gseq_cfg #(.T100(T100), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .range_sel(range_sel), .short_mode(short_mode),
    .take(take), .live_hi(hi_len), .cur_lo(lo_len), .cur_code(cur_code)
  );

  gseq_fsm #(.CNT_W(CNT_W), .STROBE_W(STROBE_W)) u_fsm (
    .clk(clk), .rst(rst), .hi_len(hi_len), .lo_len(lo_len),
    .phase_q(phase_q), .phase_nxt(phase_nxt), .take(take)
  );

  gseq_out u_out (
    .clk(clk), .rst(rst), .phase_q(phase_q), .phase_nxt(phase_nxt),
    .cur_code(cur_code), .gate(gate), .latch_n(latch_n), .clear(clear),
    .range_code(range_code)
  );

endmodule

// File: rtl/gseq_checker.sv
module gseq_checker #(
  parameter int STROBE_W = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       gate,
  input logic       latch_n,
  input logic       clear,
  input logic [1:0] range_code
);

  logic [15:0] latch_run;
  logic        seen_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_run  <= '0;
      seen_clear <= 1'b1;
    end else begin
      latch_run <= latch_n ? 16'd0 : latch_run + 16'd1;
      if (clear)     seen_clear <= 1'b1;
      else if (gate) seen_clear <= 1'b0;
    end
  end

  AST_LATCH_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_n) |-> (latch_run == 16'(STROBE_W))); // R5

  AST_CLEAR_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(clear) |-> ($past(latch_n) && !$past(latch_n, 2))); // R6

  AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(!latch_n && clear)); // R6

  AST_IDLE_ONLY_STROBES: assert property (@(posedge clk) disable iff (rst)
    gate |-> (latch_n && !clear)); // R7

  AST_RANGE_HELD: assert property (@(posedge clk) disable iff (rst)
    latch_n |-> $stable(range_code)); // R9

  AST_CLEARED_BEFORE_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> seen_clear); // R10

endmodule

bind gate_sequencer gseq_checker #(.STROBE_W(STROBE_W)) u_chk (
  .clk(clk), .rst(rst), .gate(gate), .latch_n(latch_n),
  .clear(clear), .range_code(range_code)
);

// File: tb/gate_sequencer_tb.sv
module gate_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1000;
  localparam int SW         = 4;
  localparam int T          = CLK_HZ / 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] range_sel = 2'd0;
  logic       short_mode = 1'b0;
  logic       gate, latch_n, clear;
  logic [1:0] range_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  gate_sequencer #(.CLK_HZ(CLK_HZ), .STROBE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .range_sel(range_sel), .short_mode(short_mode),
    .gate(gate), .latch_n(latch_n), .clear(clear), .range_code(range_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int f_code(int sel, bit sm);
    if (sm) return 0;
    if (sel == 3) return 1;
    return sel;
  endfunction

  function automatic int f_hi(int sel, bit sm);
    int c = f_code(sel, sm);
    return (c == 0) ? T : (c == 1) ? 10 * T : 100 * T;
  endfunction

  function automatic int f_lo(int sel, bit sm);
    if (sm) return 9 * T;
    return f_hi(sel, sm);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  int  rst_negs = 0;
  int  rsel; bit rsm;
  int  snap_sel; bit snap_sm;
  int  wsel; bit wsm;
  bit  post_rst = 1;
  bit  prev_gate = 0;
  int  hi_cnt = 0, lo_idx = 0;
  bit  lo_bad = 0, hi_bad = 0, rc_bad = 0;
  int  exp_rc = 1;
  int  windows = 0;

  always @(negedge clk) begin
    if (rst) begin
      rst_negs++;
      rsel = range_sel; rsm = short_mode;
      if (rst_negs == 2) begin
        check(gate == 1'b0,   "R1 gate in reset", gate, 0);
        check(latch_n == 1'b1,"R1 latch_n in reset", latch_n, 1);
        check(clear == 1'b1,  "R1 clear in reset", clear, 1);
        check(range_code == 2'd1, "R1 range_code in reset", range_code, 1);
      end
      post_rst = 1; prev_gate = 0; lo_idx = 0; lo_bad = 0; exp_rc = 1;
    end else begin
      if (gate && !prev_gate) begin
        if (post_rst) begin
          check(lo_idx == f_lo(rsel, rsm) - SW - 1, "R1 first low length", lo_idx, f_lo(rsel, rsm) - SW - 1);
          check(!lo_bad, "R1 strobes after reset", lo_bad, 0);
        end else begin
          check(lo_idx == f_lo(wsel, wsm), wsm ? "R4 low length" : "R3 low length", lo_idx, f_lo(wsel, wsm));
          check(!lo_bad, "R5/R6 strobe placement", lo_bad, 0);
        end
        check(!rc_bad, "R9 range_code held", rc_bad, 0);
        wsel = snap_sel; wsm = snap_sm;   // R8: setting at the opening edge
        hi_cnt = 1; hi_bad = 0; post_rst = 0; windows++;
      end else if (gate) begin
        hi_cnt++;
      end
      if (gate && (!latch_n || clear)) hi_bad = 1;
      if (!gate) begin
        bit el, ec;
        if (prev_gate) begin
          check(hi_cnt == f_hi(wsel, wsm), wsm ? "R4 high length" : "R2 high length", hi_cnt, f_hi(wsel, wsm));
          check(!hi_bad, "R7 no strobe while counting", hi_bad, 0);
          lo_idx = 0; lo_bad = 0;
          exp_rc = f_code(wsel, wsm);
          check(range_code == 2'(exp_rc), "R9 range_code at latch", range_code, exp_rc);
        end
        if (post_rst) begin el = 1; ec = (lo_idx < SW); end
        else begin el = !(lo_idx < SW); ec = (lo_idx >= SW + 1) && (lo_idx <= 2 * SW); end
        if (latch_n != el || clear != ec) lo_bad = 1;
        lo_idx++;
      end
      if (range_code != 2'(exp_rc)) rc_bad = 1;
      prev_gate = gate;
    end
    snap_sel = range_sel; snap_sm = short_mode;
  end

  // ---------------- stimulus ----------------
  task automatic set_cfg(int sel, bit sm);
    @(posedge clk); #1;
    range_sel = 2'(sel); short_mode = sm;
  endtask

  task automatic wait_windows(int n);
    repeat (n) @(posedge gate);
  endtask

  initial begin
    void'($urandom(32'd4242));
    range_sel = 2'd0; short_mode = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    wait_windows(3);                      // R2/R3 at 0.1 s
    set_cfg(1, 0); wait_windows(3);       // R2 1 s
    set_cfg(3, 0); wait_windows(2);       // R2 code 11 as 1 s
    set_cfg(0, 1); wait_windows(3);       // R4 short mode
    set_cfg(2, 0); wait_windows(2);       // R2 10 s
    set_cfg(0, 0); wait_windows(2);
    // R8: change on the last idle cycle applies; change just after the rise does not
    @(negedge gate);
    repeat (f_lo(0, 0) - 1) @(posedge clk);
    #1 range_sel = 2'd1;
    @(posedge clk); #1 range_sel = 2'd0;
    wait_windows(3);
    // R8: change mid-window is deferred
    @(posedge gate); repeat (20) @(posedge clk); #1 short_mode = 1'b1;
    wait_windows(2);
    // random mix
    for (int i = 0; i < 8; i++) begin
      int r = $urandom % 4;
      repeat ($urandom % 300) @(posedge clk);
      case (r)
        0: set_cfg(0, 0);
        1: set_cfg(1, 0);
        2: set_cfg(3, 0);
        default: set_cfg($urandom % 4, 1);
      endcase
      wait_windows(2);
    end
    @(negedge gate); @(posedge gate); @(negedge clk);
    check(windows > 20, "R2 window count", windows, 21);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", windows, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule